// File: doc/BRIEF.md
# Event Combiner and Interrupt Selector

This block collects 128 event inputs, arranged as four groups of 32, and turns them into interrupt requests for a processor. Each event is caught in a sticky flag bit. Software can set or clear any flag through write-one registers. A per-event mask decides which flags feed the combined output of each group. The four combined outputs are fed back as events 0 to 3, so a whole group can be treated as a single event.

Twelve interrupt outputs each follow the flag of one event, which software selects through a byte-wide field. A second mask per group builds an exception view of the same flags, and that view drives a single exception line. A write-only register sends a one-cycle strobe carrying the written word. Software reaches every register over a simple 32-bit word-addressed bus. Reads return their data one cycle later.

Top module: `evsel_ctrl`

## Requirements
- R1: A rising edge on an event input sets its flag bit on the next clock edge. The flag then stays set until it is cleared. An input that stays high does not set the flag again after it has been cleared.
- R2: Addresses are in 32-bit words, as address = kind*8 + index. The kinds are: 0 flag (read only), 1 set, 2 clear, 3 mask, 4 masked flag (read only), 5 exception mask, 6 masked exception flag (read only), 7 selector, 8 event assert (index 0 only). For kinds 0 to 6, index g is the group, and group g holds events 32g to 32g+31 with event 32g+b at bit b. Writing 1 to a bit of the set register sets that flag. Writing 1 to a bit of the clear register clears it. A 0 bit in either register leaves the flag unchanged.
- R3: An input edge that arrives in the same cycle as a clear of the same bit leaves the flag set.
- R4: A mask bit of 1 blocks its event and a 0 passes it. The masked-flag register of a group reads as flag AND NOT mask. Combined output k is high exactly when masked flag k is nonzero.
- R5: Flag bits 0 to 3 of group 0 latch rising edges of combined outputs 0 to 3.
- R6: Interrupt output n follows the flag of the event chosen by its 8-bit selector. That selector sits at bits (n mod 4)*8 of selector register n/4. Selector registers read back what was written.
- R7: A selector value below 4 (a combined event) or of 128 and above keeps its output low.
- R8: The masked-exception-flag register of a group reads as flag AND NOT exception mask. The exception output is high when any such bit is set in any group.
- R9: A write to the event-assert register drives the strobe output high for exactly one cycle, with the written word on the value output.
- R10: Read data appears on the cycle after the read request. Reserved addresses, and the set, clear and assert registers, read as zero. Writes to reserved addresses change no state.
- R11: After reset, flags and selectors are zero and both masks of every group are all ones. Writing all ones to the mask and clear registers of a group leaves it with no pending flag and its combined output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write request |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| evt_in | input | 124 | Event inputs 4 to 127 (events 0 to 3 are internal) |
| comb_out | output | 4 | Combined output of each group |
| irq_out | output | 12 | Routed interrupt outputs |
| exc_out | output | 1 | Combined exception output |
| evt_strobe | output | 1 | One-cycle pulse on an event-assert write |
| evt_value | output | 32 | Word last written to the event-assert register |

## Verification
A flag bit that is stuck or lost shows up in three places at once: the flag readback, any interrupt output that selects that event, and the combined output of its group once the bit is unmasked. All three change on the clock edge after the stimulus. A wrong mask bit changes the combined or exception line directly, while the raw flag readback stays the same, so the two views together locate the fault. A selector that decodes the wrong byte lane, or lets a combined event through, drives the wrong bit of irq_out. The bench sees this as soon as the flag involved is set.

// File: rtl/evsel_pkg.sv
package evsel_pkg;
   localparam int KIND_W = 4;
   localparam int SUB_W  = 3;

   localparam logic [KIND_W-1:0] K_FLAG   = 4'd0;
   localparam logic [KIND_W-1:0] K_SET    = 4'd1;
   localparam logic [KIND_W-1:0] K_CLR    = 4'd2;
   localparam logic [KIND_W-1:0] K_MASK   = 4'd3;
   localparam logic [KIND_W-1:0] K_MFLAG  = 4'd4;
   localparam logic [KIND_W-1:0] K_XMASK  = 4'd5;
   localparam logic [KIND_W-1:0] K_XFLAG  = 4'd6;
   localparam logic [KIND_W-1:0] K_MUX    = 4'd7;
   localparam logic [KIND_W-1:0] K_ASSERT = 4'd8;
endpackage

// File: rtl/evsel_group.sv
module evsel_group #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw,
   input  logic         wr_set,
   input  logic         wr_clr,
   input  logic         wr_mask,
   input  logic         wr_xmask,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] flag,
   output logic [W-1:0] mask,
   output logic [W-1:0] xmask,
   output logic [W-1:0] mflag,
   output logic [W-1:0] xflag,
   output logic         any_m,
   output logic         any_x
);
   logic [W-1:0] prev_q;
   logic [W-1:0] rise;
   logic [W-1:0] set_bits;
   logic [W-1:0] clr_bits;
   logic [W-1:0] flag_d;

   // An edge or a set outranks a clear in the same cycle.
   always_comb begin
      rise     = raw & ~prev_q;
      set_bits = wr_set ? wdata : '0;
      clr_bits = wr_clr ? wdata : '0;
      flag_d   = (flag & ~clr_bits) | set_bits | rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         flag   <= '0;
         mask   <= '1;
         xmask  <= '1;
      end else begin
         prev_q <= raw;
         flag   <= flag_d;
         if (wr_mask)  mask  <= wdata;
         if (wr_xmask) xmask <= wdata;
      end
   end

   always_comb begin
      mflag = flag & ~mask;
      xflag = flag & ~xmask;
      any_m = |mflag;
      any_x = |xflag;
   end
endmodule

// File: rtl/evsel_route.sv
module evsel_route #(
   parameter int NUM_EVT    = 128,
   parameter int NUM_GROUPS = 4,
   parameter int NUM_IRQ    = 12,
   parameter int SEL_W      = 8,
   parameter int DATA_W     = 32,
   parameter int NUM_MUXREG = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_MUXREG-1:0]    wr_en,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [NUM_EVT-1:0]       flags,
   output logic [NUM_IRQ*SEL_W-1:0] sel_flat,
   output logic [NUM_IRQ-1:0]       irq
);
   localparam int FP = DATA_W / SEL_W;

   for (genvar n = 0; n < NUM_IRQ; n++) begin : g_out
      localparam int REG = n / FP;
      localparam int LANE = (n % FP) * SEL_W;
      logic [SEL_W-1:0] sel_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          sel_q <= '0;
         else if (wr_en[REG]) sel_q <= wdata[LANE +: SEL_W];
      end

      // Only plain events are eligible; combined ones and out-of-range codes stay low.
      always_comb begin
         irq[n] = 1'b0;
         for (int e = NUM_GROUPS; e < NUM_EVT; e++)
            if (sel_q == SEL_W'(e)) irq[n] = flags[e];
      end

      assign sel_flat[n*SEL_W +: SEL_W] = sel_q;
   end
endmodule

// File: rtl/evsel_ctrl.sv
module evsel_ctrl
   import evsel_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int GROUP_W    = 32,
   parameter int NUM_IRQ    = 12,
   parameter int SEL_W      = 8,
   parameter int ADDR_W     = 7
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 bus_wr,
   input  logic                                 bus_rd,
   input  logic [ADDR_W-1:0]                    bus_addr,
   input  logic [GROUP_W-1:0]                   bus_wdata,
   output logic [GROUP_W-1:0]                   bus_rdata,
   input  logic [NUM_GROUPS*GROUP_W-1:NUM_GROUPS] evt_in,
   output logic [NUM_GROUPS-1:0]                comb_out,
   output logic [NUM_IRQ-1:0]                   irq_out,
   output logic                                 exc_out,
   output logic                                 evt_strobe,
   output logic [GROUP_W-1:0]                   evt_value
);
   localparam int NUM_EVT    = NUM_GROUPS * GROUP_W;
   localparam int FP         = GROUP_W / SEL_W;
   localparam int NUM_MUXREG = (NUM_IRQ + FP - 1) / FP;

   if (ADDR_W != KIND_W + SUB_W) begin : g_bad_addr
      $error("evsel_ctrl: ADDR_W must equal KIND_W + SUB_W");
   end
   if (GROUP_W % SEL_W != 0) begin : g_bad_lane
      $error("evsel_ctrl: selector fields must tile a register");
   end
   if (NUM_GROUPS > (1 << SUB_W) || NUM_MUXREG > (1 << SUB_W)) begin : g_bad_idx
      $error("evsel_ctrl: index field too narrow");
   end
   if ((1 << SEL_W) < NUM_EVT) begin : g_bad_sel
      $error("evsel_ctrl: selector cannot reach every event");
   end

   logic [KIND_W-1:0] kind;
   logic [SUB_W-1:0]  sub;
   assign kind = bus_addr[ADDR_W-1:SUB_W];
   assign sub  = bus_addr[SUB_W-1:0];

   logic [NUM_EVT-1:0]       raw_all;
   logic [NUM_EVT-1:0]       flag_all;
   logic [NUM_IRQ*SEL_W-1:0] sel_flat;
   logic [NUM_GROUPS-1:0]    any_x;
   logic [GROUP_W-1:0]       grp_flag  [NUM_GROUPS];
   logic [GROUP_W-1:0]       grp_mask  [NUM_GROUPS];
   logic [GROUP_W-1:0]       grp_xmask [NUM_GROUPS];
   logic [GROUP_W-1:0]       grp_mflag [NUM_GROUPS];
   logic [GROUP_W-1:0]       grp_xflag [NUM_GROUPS];
   logic [GROUP_W-1:0]       mux_rd    [NUM_MUXREG];
   logic [NUM_MUXREG-1:0]    wr_mux;

   // The combined outputs re-enter as the lowest events.
   assign raw_all = {evt_in, comb_out};

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic hit;
      assign hit = bus_wr && (sub == SUB_W'(g));

      evsel_group #(.W(GROUP_W)) u_grp (
         .clk      (clk),
         .rst_n    (rst_n),
         .raw      (raw_all[g*GROUP_W +: GROUP_W]),
         .wr_set   (hit && kind == K_SET),
         .wr_clr   (hit && kind == K_CLR),
         .wr_mask  (hit && kind == K_MASK),
         .wr_xmask (hit && kind == K_XMASK),
         .wdata    (bus_wdata),
         .flag     (grp_flag[g]),
         .mask     (grp_mask[g]),
         .xmask    (grp_xmask[g]),
         .mflag    (grp_mflag[g]),
         .xflag    (grp_xflag[g]),
         .any_m    (comb_out[g]),
         .any_x    (any_x[g])
      );

      assign flag_all[g*GROUP_W +: GROUP_W] = grp_flag[g];
   end

   assign exc_out = |any_x;

   for (genvar r = 0; r < NUM_MUXREG; r++) begin : g_muxreg
      assign wr_mux[r] = bus_wr && kind == K_MUX && sub == SUB_W'(r);
      for (genvar f = 0; f < FP; f++) begin : g_lane
         if (r * FP + f < NUM_IRQ) begin : g_used
            assign mux_rd[r][f*SEL_W +: SEL_W] = sel_flat[(r*FP+f)*SEL_W +: SEL_W];
         end else begin : g_spare
            assign mux_rd[r][f*SEL_W +: SEL_W] = '0;
         end
      end
   end

   evsel_route #(
      .NUM_EVT    (NUM_EVT),
      .NUM_GROUPS (NUM_GROUPS),
      .NUM_IRQ    (NUM_IRQ),
      .SEL_W      (SEL_W),
      .DATA_W     (GROUP_W),
      .NUM_MUXREG (NUM_MUXREG)
   ) u_route (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_mux),
      .wdata    (bus_wdata),
      .flags    (flag_all),
      .sel_flat (sel_flat),
      .irq      (irq_out)
   );

   logic [GROUP_W-1:0] rd_next;
   always_comb begin
      rd_next = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (sub == SUB_W'(g)) begin
            case (kind)
               K_FLAG:  rd_next = grp_flag[g];
               K_MASK:  rd_next = grp_mask[g];
               K_MFLAG: rd_next = grp_mflag[g];
               K_XMASK: rd_next = grp_xmask[g];
               K_XFLAG: rd_next = grp_xflag[g];
               default: ;
            endcase
         end
      end
      for (int r = 0; r < NUM_MUXREG; r++)
         if (kind == K_MUX && sub == SUB_W'(r)) rd_next = mux_rd[r];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         evt_strobe <= 1'b0;
         evt_value  <= '0;
      end else begin
         bus_rdata  <= bus_rd ? rd_next : '0;
         evt_strobe <= bus_wr && kind == K_ASSERT && sub == '0;
         if (bus_wr && kind == K_ASSERT && sub == '0) evt_value <= bus_wdata;
      end
   end
endmodule

// File: rtl/evsel_ctrl_sva.sv
module evsel_ctrl_sva
   import evsel_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int GROUP_W    = 32,
   parameter int NUM_IRQ    = 12,
   parameter int SEL_W      = 8,
   parameter int ADDR_W     = 7
) (
   input logic                                  clk,
   input logic                                  rst_n,
   input logic                                  bus_wr,
   input logic                                  bus_rd,
   input logic [ADDR_W-1:0]                     bus_addr,
   input logic [GROUP_W-1:0]                    bus_rdata,
   input logic [NUM_GROUPS*GROUP_W-1:NUM_GROUPS] evt_in,
   input logic [NUM_GROUPS*GROUP_W-1:0]         flag_all,
   input logic [NUM_IRQ*SEL_W-1:0]              sel_flat,
   input logic [NUM_IRQ-1:0]                    irq_out,
   input logic [NUM_GROUPS-1:0]                 comb_out,
   input logic                                  exc_out,
   input logic                                  evt_strobe
);
   localparam int NUM_EVT    = NUM_GROUPS * GROUP_W;
   localparam int FP         = GROUP_W / SEL_W;
   localparam int NUM_MUXREG = (NUM_IRQ + FP - 1) / FP;

   logic past_valid;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) past_valid <= 1'b0;
      else        past_valid <= 1'b1;

   logic [KIND_W-1:0] kind;
   logic [SUB_W-1:0]  sub;
   logic              zero_rd;
   assign kind = bus_addr[ADDR_W-1:SUB_W];
   assign sub  = bus_addr[SUB_W-1:0];
   always_comb begin
      zero_rd = 1'b0;
      if (kind > K_ASSERT) zero_rd = 1'b1;
      if (kind == K_ASSERT || kind == K_SET || kind == K_CLR) zero_rd = 1'b1;
      if (kind < K_MUX && int'(sub) >= NUM_GROUPS) zero_rd = 1'b1;
      if (kind == K_MUX && int'(sub) >= NUM_MUXREG) zero_rd = 1'b1;
   end

   function automatic logic pick(input logic [SEL_W-1:0] s, input logic [NUM_EVT-1:0] fl);
      logic v = 1'b0;
      for (int e = 0; e < NUM_EVT; e++) if (s == SEL_W'(e)) v = fl[e];
      return v;
   endfunction

   for (genvar i = NUM_GROUPS; i < NUM_EVT; i++) begin : g_edge
      assert_edge_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
         past_valid && $rose(evt_in[i]) |=> flag_all[i]);
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_comb
      assert_comb_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
         comb_out[g] |-> |flag_all[g*GROUP_W +: GROUP_W]);
   end

   for (genvar n = 0; n < NUM_IRQ; n++) begin : g_irq
      assert_irq_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
         irq_out[n] |-> (int'(sel_flat[n*SEL_W +: SEL_W]) >= NUM_GROUPS &&
                         int'(sel_flat[n*SEL_W +: SEL_W]) < NUM_EVT));
      assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
         irq_out[n] |-> pick(sel_flat[n*SEL_W +: SEL_W], flag_all));
   end

   assert_exc_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_out |-> |flag_all);

   assert_strobe_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid && evt_strobe |-> $past(bus_wr) && $past(kind) == K_ASSERT && $past(sub) == '0);

   assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid && $past(bus_rd) && $past(zero_rd) |-> bus_rdata == '0);
endmodule

bind evsel_ctrl evsel_ctrl_sva #(
   .NUM_GROUPS (NUM_GROUPS),
   .GROUP_W    (GROUP_W),
   .NUM_IRQ    (NUM_IRQ),
   .SEL_W      (SEL_W),
   .ADDR_W     (ADDR_W)
) u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_addr   (bus_addr),
   .bus_rdata  (bus_rdata),
   .evt_in     (evt_in),
   .flag_all   (flag_all),
   .sel_flat   (sel_flat),
   .irq_out    (irq_out),
   .comb_out   (comb_out),
   .exc_out    (exc_out),
   .evt_strobe (evt_strobe)
);

// File: tb/evsel_ctrl_bench.sv
module evsel_ctrl_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr = 1'b0;
   logic         bus_rd = 1'b0;
   logic [6:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [127:4] evt_in = '0;
   logic [3:0]   comb_out;
   logic [11:0]  irq_out;
   logic         exc_out;
   logic         evt_strobe;
   logic [31:0]  evt_value;

   int nvec = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   evsel_ctrl u_evsel_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_in(evt_in), .comb_out(comb_out), .irq_out(irq_out),
      .exc_out(exc_out), .evt_strobe(evt_strobe), .evt_value(evt_value)
   );

   // kind codes as in R2
   localparam int FLAG = 0, SET = 1, CLR = 2, MASK = 3, MFLAG = 4,
                  XMASK = 5, XFLAG = 6, MUX = 7, ASRT = 8;

   function automatic logic [6:0] adr(input int kind, input int idx);
      return 7'(kind * 8 + idx);
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      nvec++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input int kind, input int idx, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = adr(kind, idx); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int kind, input int idx, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = adr(kind, idx);
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R11 irq idle", 32'(irq_out), 32'h0);
      chk("R11 comb idle", 32'(comb_out), 32'h0);
      chk("R11 exc idle", 32'(exc_out), 32'h0);
      rd(MASK, 2, d);  chk("R11 mask reset", d, 32'hFFFF_FFFF);
      rd(XMASK, 0, d); chk("R11 xmask reset", d, 32'hFFFF_FFFF);
      rd(FLAG, 1, d);  chk("R11 flag reset", d, 32'h0);
      rd(MUX, 1, d);   chk("R11 selector reset", d, 32'h0);
   endtask

   task automatic t_edge;
      logic [31:0] d;
      @(negedge clk); evt_in[37] = 1'b1;
      rd(FLAG, 1, d); chk("R1 edge latched", d, 32'h20);
      wr(CLR, 1, 32'h20);
      rd(FLAG, 1, d); chk("R1 level does not relatch", d, 32'h0);
      evt_in[37] = 1'b0;
   endtask

   task automatic t_setclr;
      logic [31:0] d;
      wr(SET, 2, 32'hF0);
      rd(FLAG, 2, d); chk("R2 set", d, 32'hF0);
      wr(SET, 2, 32'h0); wr(CLR, 2, 32'h0);
      rd(FLAG, 2, d); chk("R2 zero writes ignored", d, 32'hF0);
      wr(CLR, 2, 32'h30);
      rd(FLAG, 2, d); chk("R2 clear", d, 32'hC0);
      rd(SET, 2, d);  chk("R10 set reads zero", d, 32'h0);
      wr(CLR, 2, 32'hFFFF_FFFF);
   endtask

   task automatic t_edge_vs_clr;
      logic [31:0] d;
      wr(SET, 3, 32'h80);
      @(negedge clk);
      evt_in[103] = 1'b1;
      bus_wr = 1'b1; bus_addr = adr(CLR, 3); bus_wdata = 32'h80;
      @(negedge clk);
      bus_wr = 1'b0;
      rd(FLAG, 3, d); chk("R3 edge beats clear", d, 32'h80);
      evt_in[103] = 1'b0;
      wr(CLR, 3, 32'hFFFF_FFFF);
   endtask

   task automatic t_mask;
      logic [31:0] d;
      wr(SET, 1, 32'h20);
      chk("R4 masked comb low", 32'(comb_out), 32'h0);
      rd(MFLAG, 1, d); chk("R4 masked view empty", d, 32'h0);
      wr(MASK, 1, 32'hFFFF_FFDF);
      chk("R4 comb high", 32'(comb_out), 32'h2);
      rd(MFLAG, 1, d); chk("R4 masked view", d, 32'h20);
      rd(FLAG, 0, d);  chk("R5 combined event latched", d, 32'h2);
      wr(MASK, 1, 32'hFFFF_FFFF);
      wr(CLR, 1, 32'hFFFF_FFFF);
      wr(CLR, 0, 32'hFFFF_FFFF);
      rd(FLAG, 1, d);  chk("R11 no pending", d, 32'h0);
      rd(MFLAG, 1, d); chk("R11 masked empty", d, 32'h0);
      chk("R11 comb low", 32'(comb_out), 32'h0);
   endtask

   task automatic t_route;
      logic [31:0] d;
      wr(MUX, 0, 32'h0000_2500);
      wr(MUX, 1, 32'h0000_6400);
      wr(MUX, 2, 32'h6400_0000);
      rd(MUX, 1, d); chk("R6 selector readback", d, 32'h0000_6400);
      wr(SET, 1, 32'h20);
      chk("R6 irq1 follows event 37", 32'(irq_out), 32'h002);
      wr(SET, 3, 32'h10);
      chk("R6 irq5 irq11 follow event 100", 32'(irq_out), 32'h822);
      wr(CLR, 1, 32'h20);
      chk("R6 irq1 drops", 32'(irq_out), 32'h820);
      wr(CLR, 3, 32'hFFFF_FFFF);
      chk("R6 all low", 32'(irq_out), 32'h0);
   endtask

   task automatic t_sel_range;
      wr(MUX, 0, 32'h0000_0002);
      wr(MUX, 2, 32'h0000_00C8);
      for (int g = 0; g < 4; g++) wr(SET, g, 32'hFFFF_FFFF);
      chk("R7 only in-range selector fires", 32'(irq_out), 32'h020);
      for (int g = 0; g < 4; g++) wr(CLR, g, 32'hFFFF_FFFF);
   endtask

   task automatic t_exc;
      logic [31:0] d;
      wr(SET, 2, 32'h200);
      chk("R8 exc masked", 32'(exc_out), 32'h0);
      rd(XFLAG, 2, d); chk("R8 xflag empty", d, 32'h0);
      wr(XMASK, 2, 32'hFFFF_FDFF);
      chk("R8 exc high", 32'(exc_out), 32'h1);
      chk("R4 comb unaffected by xmask", 32'(comb_out), 32'h0);
      rd(XFLAG, 2, d); chk("R8 xflag view", d, 32'h200);
      rd(XMASK, 2, d); chk("R8 xmask readback", d, 32'hFFFF_FDFF);
      wr(CLR, 2, 32'h200);
      chk("R8 exc cleared", 32'(exc_out), 32'h0);
      wr(XMASK, 2, 32'hFFFF_FFFF);
   endtask

   task automatic t_assert;
      wr(ASRT, 0, 32'hA5A5_0001);
      chk("R9 strobe", 32'(evt_strobe), 32'h1);
      chk("R9 value", evt_value, 32'hA5A5_0001);
      @(negedge clk);
      chk("R9 single cycle", 32'(evt_strobe), 32'h0);
   endtask

   task automatic t_reserved;
      logic [31:0] d;
      wr(9, 0, 32'hFFFF_FFFF);
      wr(MASK, 5, 32'h0);
      rd(9, 0, d);    chk("R10 reserved reads zero", d, 32'h0);
      rd(MASK, 5, d); chk("R10 spare index reads zero", d, 32'h0);
      rd(ASRT, 0, d); chk("R10 assert reads zero", d, 32'h0);
      for (int g = 0; g < 4; g++) begin
         rd(MASK, g, d); chk("R10 reserved write ignored", d, 32'hFFFF_FFFF);
      end
      chk("R10 outputs unchanged", 32'({irq_out, comb_out, exc_out}), 32'h0);
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_edge;
      t_setclr;
      t_edge_vs_clr;
      t_mask;
      t_route;
      t_sel_range;
      t_exc;
      t_assert;
      t_reserved;
      done = 1'b1;
      finish_run;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nvec++;
         nerr++;
         $display("FAIL watchdog got timeout expected completion");
         finish_run;
      end
   end
endmodule